// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh

This block sits in a DRAM controller and keeps every row of an asynchronous DRAM refreshed within its refresh period. The period is 128 ms for both the 4096-row and the 2048-row option. An interval timer, derived from the clock frequency, adds one refresh to a debt counter every row interval: 31.25 µs with 4096 rows, 62.5 µs with 2048 rows. Each unit of debt is paid with a CAS-before-RAS (CBR) cycle. In such a cycle the device takes the row from its own internal counter, so the block drives strobes only and never a row address.

Normal accesses ask through a request/grant handshake. The block may let up to a set number of refreshes wait behind accesses. Once that limit is reached, the refresh wins as soon as the current access ends. Between any two cycles, RAS is held high for a precharge time.

A sleep request puts the device into self refresh. The block runs a CBR cycle and then keeps RAS (and CAS) low for at least a minimum hold. When sleep is dropped, it raises RAS and holds it high for an exit time. After that exit, a distributed-style controller restarts its timer with no debt. A burst-style controller instead owes a full pass over all rows, and it must complete that pass before any access is granted.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset, `ras_n` and `cas_n` are 1, `acc_gnt` and `sr_active` are 0 and `owed` is 0.
- R2: With no access and no sleep request, successive falls of `ras_n` are exactly INTERVAL cycles apart. INTERVAL is CLK_MHZ times 31250 ns (4096 rows) or 62500 ns (2048 rows), divided by 1000.
- R3: Every refresh is a CBR cycle. `cas_n` goes low T_CSR cycles before `ras_n` falls, and `ras_n` is never low while `cas_n` is high. Outside self refresh, `ras_n` stays low for exactly T_RAS cycles.
- R4: After every refresh or access, `ras_n` and `cas_n` stay high and `acc_gnt` stays low for at least T_RP cycles before the next cycle starts.
- R5: When the block is idle, owes nothing and sees `acc_req` high, it raises `acc_gnt` one cycle later. The grant holds until `acc_done` is seen, and drops the cycle after. A pulse on `acc_done` while `acc_gnt` is low changes no output.
- R6: `acc_gnt` never rises when `owed` was at least MAX_POSTPONE in the deciding cycle. If accesses are shorter than INTERVAL, `owed` never exceeds MAX_POSTPONE, and an idle block pays its debt down to 0.
- R7: A sleep request starts a CBR cycle. After that cycle, `sr_active` rises with `ras_n` and `cas_n` still low, and `owed` reads 0. `ras_n` stays low for at least T_RAS+T_SRE cycles and for as long as `sleep_req` is held, with no refresh pulse in between.
- R8: After `sleep_req` falls and the minimum hold has passed, `ras_n` goes high while `sr_active` stays high for exactly T_RPS cycles. No grant is given during that time.
- R9: With EXIT_BURST=0, `owed` is 0 after exit and the timer restarts. The first refresh `ras_n` fall comes INTERVAL+T_CSR+1 cycles after `sr_active` falls.
- R10: With EXIT_BURST=1, `owed` reads the row count (2048 or 4096) on the first cycle after exit. At least that many refreshes run before `acc_gnt` rises again.
- R11: `owed` counts timer intervals that have not yet been paid. While an access is held, it increases by one every INTERVAL cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | Access controller wants a memory cycle |
| acc_done | input | 1 | Granted access cycle has ended (one-cycle pulse) |
| sleep_req | input | 1 | Level request for self refresh |
| acc_gnt | output | 1 | Access may run; held until `acc_done` |
| ras_n | output | 1 | Row strobe for refresh and self refresh, active low |
| cas_n | output | 1 | Column strobe for CBR and self refresh, active low |
| sr_active | output | 1 | Device is in, or leaving, self refresh |
| owed | output | OWED_W | Refreshes owed (13 bits for 4096 rows, 12 for 2048) |

## Verification
The grant is due one cycle after a request seen in the idle state, and it drops one cycle after `acc_done`. A refresh `ras_n` fall is due T_CSR+1 cycles after the interval tick, and on exit from self refresh the first one lands INTERVAL+T_CSR+1 cycles after `sr_active` falls. The bench drives on the falling clock edge and samples every output there. It counts cycles in falling-edge steps from the triggering observation, so each result is compared in the exact cycle it becomes due. Strobe widths, lead times and precharge gaps are measured as run lengths of sampled levels, not read from internal state.

// File: rtl/dram_refresh_pkg.sv
// Shared types and constant helpers for the refresh scheduler.
// Assumes rows are 4096 (128 ms / 31.25 us) or 2048 (128 ms / 62.5 us).
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_PRECH,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_SR_HOLD,
        ST_SR_EXIT
    } seq_state_t;

    // Number of rows to cover in one refresh period
    function automatic int rows_of(bit four_k);
        return four_k ? 4096 : 2048;
    endfunction

    // Per-row interval in nanoseconds for distributed refresh
    function automatic int row_ns(bit four_k);
        return four_k ? 31250 : 62500;
    endfunction

    // Width of the refresh debt counter (holds the full row count)
    function automatic int owed_w(bit four_k);
        return $clog2(rows_of(four_k) + 1);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Interval timer: pulses tick once every INTERVAL cycles while not held.
// Assumes INTERVAL >= 2. Hold clears the count so it restarts from zero.
module rfsh_interval_timer #(
    parameter int INTERVAL = 3906
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign tick = !hold && (cnt == LAST);

    // Count cycles, wrapping on each tick, cleared while held
    always_ff @(posedge clk) begin
        if (!rst_n || hold || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfsh_debt_counter.sv
// Refresh debt counter: +1 per timer tick, -1 per launched refresh.
// Clear (self-refresh entry) and load (burst-style exit) take priority.
module rfsh_debt_counter #(
    parameter int ROWS   = 4096,
    parameter int OWED_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              serve,
    input  logic              clear,
    input  logic              load,
    output logic [OWED_W-1:0] owed
);
    localparam logic [OWED_W-1:0] FULL     = {OWED_W{1'b1}};
    localparam logic [OWED_W-1:0] ROWS_VAL = OWED_W'(ROWS);

    // Track owed refreshes with saturation at both ends
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            owed <= '0;
        end else if (load) begin
            owed <= ROWS_VAL;
        end else begin
            unique case ({tick, serve && (owed != '0)})
                2'b10:   if (owed != FULL) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_strobe_seq.sv
// Strobe sequencer: arbitrates refresh, access and sleep, and shapes
// the CBR, precharge and self-refresh entry/exit strobe sequences.
// Assumes all timing parameters >= 1 and MAX_POSTPONE >= 1.
module rfsh_strobe_seq
    import dram_refresh_pkg::*;
#(
    parameter int OWED_W       = 13,
    parameter int T_RP         = 3,
    parameter int T_CSR        = 2,
    parameter int T_RAS        = 5,
    parameter int T_SRE        = 13,
    parameter int T_RPS        = 14,
    parameter int MAX_POSTPONE = 2,
    parameter bit EXIT_BURST   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_done,
    input  logic              sleep_req,
    input  logic [OWED_W-1:0] owed,
    output logic              acc_gnt,
    output logic              ras_n,
    output logic              cas_n,
    output logic              sr_active,
    output logic              serve,
    output logic              clear_debt,
    output logic              load_debt
);
    localparam int DMAX  = (T_RP > T_CSR ? T_RP : T_CSR) > (T_RAS > T_SRE ? T_RAS : T_SRE)
                         ? (T_RP > T_CSR ? T_RP : T_CSR) : (T_RAS > T_SRE ? T_RAS : T_SRE);
    localparam int DTOP  = DMAX > T_RPS ? DMAX : T_RPS;
    localparam int DW    = $clog2(DTOP + 1);
    localparam logic [DW-1:0] D_RP  = DW'(T_RP - 1);
    localparam logic [DW-1:0] D_CSR = DW'(T_CSR - 1);
    localparam logic [DW-1:0] D_RAS = DW'(T_RAS - 1);
    localparam logic [DW-1:0] D_SRE = DW'(T_SRE - 1);
    localparam logic [DW-1:0] D_RPS = DW'(T_RPS - 1);
    localparam logic [OWED_W-1:0] MAXP = OWED_W'(MAX_POSTPONE);

    seq_state_t      state;
    logic [DW-1:0]   dcnt;
    logic            sr_flag;
    logic            catchup;
    logic            refresh_go;
    logic            dur_done;

    assign dur_done   = (dcnt == '0);
    // Refresh wins at the postpone limit, when no access waits, or during catch-up
    assign refresh_go = (owed >= MAXP) || ((owed != '0) && (!acc_req || catchup));

    // Strobe and status outputs decoded from the registered state
    always_comb begin
        ras_n     = !(state == ST_RAS_LOW || state == ST_SR_HOLD);
        cas_n     = !(state == ST_CAS_LEAD || state == ST_RAS_LOW || state == ST_SR_HOLD);
        acc_gnt   = (state == ST_ACCESS);
        sr_active = (state == ST_SR_HOLD || state == ST_SR_EXIT);
    end

    // Debt control strobes toward the counter
    always_comb begin
        serve      = (state == ST_IDLE) && !sleep_req && refresh_go;
        clear_debt = (state == ST_RAS_LOW) && dur_done && sr_flag;
        load_debt  = EXIT_BURST && (state == ST_SR_EXIT) && dur_done;
    end

    // Sequence state, duration counter and mode flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            dcnt    <= '0;
            sr_flag <= 1'b0;
            catchup <= 1'b0;
        end else begin
            if (load_debt)          catchup <= 1'b1;
            else if (owed == '0)    catchup <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sleep_req) begin
                        state   <= ST_CAS_LEAD;
                        dcnt    <= D_CSR;
                        sr_flag <= 1'b1;
                    end else if (refresh_go) begin
                        state   <= ST_CAS_LEAD;
                        dcnt    <= D_CSR;
                        sr_flag <= 1'b0;
                    end else if (acc_req && !catchup) begin
                        state   <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (acc_done) begin
                        state <= ST_PRECH;
                        dcnt  <= D_RP;
                    end
                end
                ST_PRECH: begin
                    if (dur_done) state <= ST_IDLE;
                    else          dcnt  <= dcnt - 1'b1;
                end
                ST_CAS_LEAD: begin
                    if (dur_done) begin
                        state <= ST_RAS_LOW;
                        dcnt  <= D_RAS;
                    end else begin
                        dcnt  <= dcnt - 1'b1;
                    end
                end
                ST_RAS_LOW: begin
                    if (dur_done) begin
                        state <= sr_flag ? ST_SR_HOLD : ST_PRECH;
                        dcnt  <= sr_flag ? D_SRE : D_RP;
                    end else begin
                        dcnt  <= dcnt - 1'b1;
                    end
                end
                ST_SR_HOLD: begin
                    if (!dur_done) begin
                        dcnt <= dcnt - 1'b1;
                    end else if (!sleep_req) begin
                        state <= ST_SR_EXIT;
                        dcnt  <= D_RPS;
                    end
                end
                ST_SR_EXIT: begin
                    if (dur_done) begin
                        state   <= ST_IDLE;
                        sr_flag <= 1'b0;
                    end else begin
                        dcnt    <= dcnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Top: distributed CBR refresh scheduler with self-refresh entry/exit.
// Assumes the access controller ends each access with acc_done and keeps
// accesses shorter than one row interval so debt stays bounded.
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int CLK_MHZ      = 125,
    parameter bit ROWS_4K      = 1'b1,
    parameter int T_RP         = 3,
    parameter int T_CSR        = 2,
    parameter int T_RAS        = 5,
    parameter int T_SRE        = 13,
    parameter int T_RPS        = 14,
    parameter int MAX_POSTPONE = 2,
    parameter bit EXIT_BURST   = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_req,
    input  logic                        acc_done,
    input  logic                        sleep_req,
    output logic                        acc_gnt,
    output logic                        ras_n,
    output logic                        cas_n,
    output logic                        sr_active,
    output logic [owed_w(ROWS_4K)-1:0]  owed
);
    localparam int ROWS     = rows_of(ROWS_4K);
    localparam int OWED_W   = owed_w(ROWS_4K);
    localparam int INTERVAL = row_ns(ROWS_4K) * CLK_MHZ / 1000;

    logic tick;
    logic serve;
    logic clear_debt;
    logic load_debt;

    rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (sr_active),
        .tick  (tick)
    );

    rfsh_debt_counter #(.ROWS(ROWS), .OWED_W(OWED_W)) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .serve (serve),
        .clear (clear_debt),
        .load  (load_debt),
        .owed  (owed)
    );

    rfsh_strobe_seq #(
        .OWED_W       (OWED_W),
        .T_RP         (T_RP),
        .T_CSR        (T_CSR),
        .T_RAS        (T_RAS),
        .T_SRE        (T_SRE),
        .T_RPS        (T_RPS),
        .MAX_POSTPONE (MAX_POSTPONE),
        .EXIT_BURST   (EXIT_BURST)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .acc_done   (acc_done),
        .sleep_req  (sleep_req),
        .owed       (owed),
        .acc_gnt    (acc_gnt),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .sr_active  (sr_active),
        .serve      (serve),
        .clear_debt (clear_debt),
        .load_debt  (load_debt)
    );
endmodule

// File: rtl/rfsh_sched_checker.sv
// Protocol checker for the refresh scheduler, bound to the top module.
module rfsh_sched_checker
    import dram_refresh_pkg::*;
#(
    parameter bit ROWS_4K      = 1'b1,
    parameter int MAX_POSTPONE = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       acc_gnt,
    input logic                       ras_n,
    input logic                       cas_n,
    input logic                       sr_active,
    input logic [owed_w(ROWS_4K)-1:0] owed
);
    localparam int OW = owed_w(ROWS_4K);
    localparam logic [OW-1:0] MAXP = OW'(MAX_POSTPONE);

    // R3
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    // R3
    ras_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R4
    ras_high_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    // R5
    grant_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (ras_n && cas_n));

    // R6
    postpone_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_gnt) |-> ($past(owed) < MAXP));

    // R8
    sr_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !acc_gnt);
endmodule

bind dram_refresh_sched rfsh_sched_checker #(
    .ROWS_4K      (ROWS_4K),
    .MAX_POSTPONE (MAX_POSTPONE)
) u_rfsh_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_gnt   (acc_gnt),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .sr_active (sr_active),
    .owed      (owed)
);

// File: tb/dram_refresh_sched_bench.sv
// Bench: directed corners plus seeded random access traffic.
module dram_refresh_sched_bench;
    import dram_refresh_pkg::*;

    localparam int CLK_MHZ  = 8;
    localparam int T_RP     = 3;
    localparam int T_CSR    = 2;
    localparam int T_RAS    = 5;
    localparam int T_SRE    = 13;
    localparam int T_RPS    = 14;
    localparam int MAXP     = 2;
    localparam int OW       = owed_w(1'b1);
    localparam int BOW      = owed_w(1'b0);
    localparam int WD_LIMIT = 150000;

    // Bench model of the timing requirements
    function automatic int interval_of(bit four_k);
        return row_ns(four_k) * CLK_MHZ / 1000;
    endfunction
    localparam int INTERVAL = interval_of(1'b1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_req = 1'b0, acc_done = 1'b0, sleep_req = 1'b0;
    logic gnt, ras_n, cas_n, sr;
    logic [OW-1:0] owed;
    logic b_req = 1'b0, b_done = 1'b0, b_sleep = 1'b0;
    logic b_gnt, b_ras_n, b_cas_n, b_sr;
    logic [BOW-1:0] b_owed;

    always #4 clk = ~clk;

    dram_refresh_sched #(.CLK_MHZ(CLK_MHZ), .ROWS_4K(1'b1), .T_RP(T_RP), .T_CSR(T_CSR),
        .T_RAS(T_RAS), .T_SRE(T_SRE), .T_RPS(T_RPS), .MAX_POSTPONE(MAXP),
        .EXIT_BURST(1'b0)) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_done(acc_done),
        .sleep_req(sleep_req), .acc_gnt(gnt), .ras_n(ras_n), .cas_n(cas_n),
        .sr_active(sr), .owed(owed));

    dram_refresh_sched #(.CLK_MHZ(CLK_MHZ), .ROWS_4K(1'b0), .T_RP(T_RP), .T_CSR(T_CSR),
        .T_RAS(T_RAS), .T_SRE(T_SRE), .T_RPS(T_RPS), .MAX_POSTPONE(MAXP),
        .EXIT_BURST(1'b1)) u_dram_refresh_sched_burst (
        .clk(clk), .rst_n(rst_n), .acc_req(b_req), .acc_done(b_done),
        .sleep_req(b_sleep), .acc_gnt(b_gnt), .ras_n(b_ras_n), .cas_n(b_cas_n),
        .sr_active(b_sr), .owed(b_owed));

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor state
    int  cyc = 0;
    bit  mon_on = 1'b0;
    int  cas_lead = 0, ras_low = 0, quiet = 0;
    bit  pulse_sr = 1'b0, quiet_valid = 1'b0, prev_busy = 1'b0;
    bit  prev_ras = 1'b1, prev_gnt = 1'b0;
    int  prev_owed = 0;
    bit  idle_mode = 1'b0, last_valid = 1'b0;
    int  last_fall = 0, falls = 0, max_owed = 0;

    // Watchdog: an expired run is a failed check
    always @(negedge clk) begin
        if (cyc >= WD_LIMIT && !finished) begin
            chk(1'b0, "watchdog (all requirements)", cyc, WD_LIMIT);
            finish_run();
        end
    end

    // Strobe monitor on the distributed-style instance
    always @(negedge clk) begin
        bit busy;
        cyc++;
        if (rst_n && mon_on) begin
            if (!cas_n && ras_n) cas_lead++;
            else if (cas_n)      cas_lead = 0;
            if (prev_ras && !ras_n) begin
                chk(cas_lead == T_CSR, "R3 cas lead before ras fall", cas_lead, T_CSR);
                falls++;
                if (idle_mode && last_valid)
                    chk(cyc - last_fall == INTERVAL, "R2 idle refresh spacing", cyc - last_fall, INTERVAL);
                last_fall  = cyc;
                last_valid = idle_mode;
                ras_low    = 0;
                pulse_sr   = 1'b0;
            end
            if (!ras_n) begin
                ras_low++;
                if (sr) pulse_sr = 1'b1;
            end
            if (!prev_ras && ras_n) begin
                if (pulse_sr) chk(ras_low >= T_RAS + T_SRE, "R7 self-refresh ras low width", ras_low, T_RAS + T_SRE);
                else          chk(ras_low == T_RAS, "R3 refresh ras low width", ras_low, T_RAS);
            end
            if (!prev_gnt && gnt)
                chk(prev_owed < MAXP, "R6 grant under postpone limit", prev_owed, MAXP - 1);
            busy = !ras_n || !cas_n || gnt;
            if (busy) begin
                if (!prev_busy && quiet_valid)
                    chk(quiet >= T_RP, "R4 precharge gap", quiet, T_RP);
                quiet_valid = 1'b1;
                quiet = 0;
            end else begin
                quiet++;
            end
            prev_busy = busy;
            if (int'(owed) > max_owed) max_owed = int'(owed);
        end
        prev_ras  = ras_n;
        prev_gnt  = gnt;
        prev_owed = int'(owed);
    end

    task automatic wait_quiet();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!gnt && ras_n && cas_n && owed == '0) break;
        end
    endtask

    initial begin
        int t1, t2, lowc, highc, n, f0, highs, bfalls;
        bit bprev;
        void'($urandom(32'd4242));

        // R1: reset values
        repeat (4) @(negedge clk);
        chk(ras_n == 1'b1 && cas_n == 1'b1, "R1 strobes high in reset", {ras_n, cas_n}, 3);
        chk(gnt == 1'b0 && sr == 1'b0, "R1 grant/sr low in reset", {gnt, sr}, 0);
        chk(owed == '0, "R1 owed zero in reset", owed, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R5: grant latency, hold, release
        acc_req = 1'b1;
        @(negedge clk);
        chk(gnt == 1'b1, "R5 grant one cycle after request", gnt, 1);
        repeat (10) @(negedge clk);
        chk(gnt == 1'b1, "R5 grant held until done", gnt, 1);
        acc_done = 1'b1;
        acc_req  = 1'b0;
        @(negedge clk);
        acc_done = 1'b0;
        chk(gnt == 1'b0, "R5 grant drops after done", gnt, 0);
        // R5: stray done while idle is ignored
        repeat (6) @(negedge clk);
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
        @(negedge clk);
        chk(gnt == 1'b0 && ras_n && cas_n, "R5 stray done ignored", {gnt, ras_n, cas_n}, 3);

        // R11: debt grows once per interval during a long access
        wait_quiet();
        acc_req = 1'b1;
        @(negedge clk);
        chk(gnt == 1'b1, "R11 setup grant", gnt, 1);
        t1 = 0; t2 = 0;
        for (int i = 0; i < 3 * INTERVAL; i++) begin
            @(negedge clk);
            if (owed == OW'(1) && t1 == 0) t1 = cyc;
            if (owed == OW'(2)) begin t2 = cyc; break; end
        end
        chk(t1 != 0 && t2 - t1 == INTERVAL, "R11 owed step per interval", t2 - t1, INTERVAL);
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
        // R6: refresh served first, then grant with owed below the limit
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (gnt) break;
        end
        chk(gnt == 1'b1 && owed == OW'(1), "R6 one refresh before regrant", owed, 1);
        acc_done = 1'b1;
        acc_req  = 1'b0;
        @(negedge clk);
        acc_done = 1'b0;
        repeat (40) @(negedge clk);
        chk(owed == '0, "R6 idle drains debt", owed, 0);

        // R6: random access traffic keeps debt bounded
        max_owed = 0;
        falls = 0;
        t1 = cyc;
        while (cyc - t1 < 6000) begin
            int len, gap;
            acc_req = 1'b1;
            for (int i = 0; i < 1000; i++) begin
                @(negedge clk);
                if (gnt) break;
            end
            len = $urandom_range(20, 120);
            repeat (len) @(negedge clk);
            gap = $urandom_range(0, 30);
            acc_done = 1'b1;
            acc_req  = (gap == 0);
            @(negedge clk);
            acc_done = 1'b0;
            if (gap > 0) repeat (gap) @(negedge clk);
        end
        acc_req = 1'b0;
        t2 = cyc - t1;
        chk(max_owed <= MAXP, "R6 owed never above limit", max_owed, MAXP);
        chk(falls >= t2 / INTERVAL - MAXP - 1, "R6 refreshes keep pace", falls, t2 / INTERVAL - MAXP - 1);
        @(negedge clk);
        if (gnt) begin
            acc_done = 1'b1;
            @(negedge clk);
            acc_done = 1'b0;
        end

        // R2: idle spacing
        repeat (60) @(negedge clk);
        last_valid = 1'b0;
        idle_mode  = 1'b1;
        repeat (4 * INTERVAL + 10) @(negedge clk);
        idle_mode = 1'b0;
        chk(owed <= OW'(1), "R2 no debt build-up when idle", owed, 0);

        // R7/R8: short sleep with access pending
        wait_quiet();
        sleep_req = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sr) break;
        end
        sleep_req = 1'b0;
        chk(sr && !ras_n && !cas_n, "R7 sr entered with strobes low", {sr, ras_n, cas_n}, 4);
        chk(owed == '0, "R7 debt cleared on entry", owed, 0);
        acc_req = 1'b1;
        lowc = 1; highc = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!sr) break;
            if (gnt) chk(1'b0, "R8 no grant in self refresh", 1, 0);
            if (!ras_n) lowc++; else highc++;
        end
        chk(lowc == T_SRE, "R7 minimum sr hold", lowc, T_SRE);
        chk(highc == T_RPS, "R8 exit ras high time", highc, T_RPS);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gnt) break;
        end
        acc_done = 1'b1;
        acc_req  = 1'b0;
        @(negedge clk);
        acc_done = 1'b0;

        // R7/R9: long sleep, then first refresh after exit
        wait_quiet();
        sleep_req = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sr) break;
        end
        f0 = falls;
        highs = 0;
        repeat (200) begin
            @(negedge clk);
            if (ras_n) highs++;
        end
        chk(highs == 0 && falls == f0, "R7 ras held low while sleeping", highs, 0);
        sleep_req = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!sr) break;
        end
        chk(owed == '0, "R9 no debt after distributed exit", owed, 0);
        n = 0;
        for (int i = 0; i < 2 * INTERVAL; i++) begin
            if (!ras_n) break;
            @(negedge clk);
            n++;
        end
        chk(n == INTERVAL + T_CSR + 1, "R9 first refresh after exit", n, INTERVAL + T_CSR + 1);

        // R10: burst-style exit owes all rows before access
        b_sleep = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (b_sr) break;
        end
        b_sleep = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!b_sr) break;
        end
        chk(b_owed == BOW'(rows_of(1'b0)), "R10 full row debt after exit", b_owed, rows_of(1'b0));
        b_req = 1'b1;
        bfalls = 0;
        bprev = b_ras_n;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (bprev && !b_ras_n) bfalls++;
            bprev = b_ras_n;
            if (b_gnt) break;
        end
        chk(b_gnt == 1'b1 && bfalls >= rows_of(1'b0), "R10 catch-up before grant", bfalls, rows_of(1'b0));
        chk(b_owed <= BOW'(1), "R10 debt paid at grant", b_owed, 0);
        b_done = 1'b1;
        b_req  = 1'b0;
        @(negedge clk);
        b_done = 1'b0;
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule